// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and walks the memory through its required start-up sequence after reset. It holds the clock enable low until a single power-good input says the rails are settled. It then waits for a parameterised number of stable-clock cycles, raises clock enable while sending NOPs, and issues the fixed command train. That train enables the DLL, resets it, waits for it to lock, refreshes the device, and ends by loading the final mode register word.

Every wait is a count of controller clock cycles, and each count is a parameter. The mode register words come in as parameters. The sequencer forces only the DLL-disable bit of the extended word and the DLL-reset bit of the base word. When the last gap has elapsed, a done flag rises and the command pins stay at NOP, so that the normal controller can take over.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and afterwards for as long as `pwr_good` stays low, `cke` is 0 and `init_done` is 0. The pins then show NOP: `cs_n`,`ras_n`,`cas_n`,`we_n` = 0,1,1,1.
- R2: The `pwr_good` input is sampled high at a clock edge. From that edge, `cke` stays 0 for exactly STABLE_CYC more cycles, and no command other than NOP appears while `cke` is 0.
- R3: After `cke` rises, it stays high. NOPs are driven for CKE_NOP_CYC cycles, and then precharge-all is issued: pins 0,0,1,0, `addr[10]`=1, `ba`=0.
- R4: The commands issued (any pin pattern other than NOP) come in this exact order: precharge-all, extended mode set, mode set with DLL reset, precharge-all, NUM_REF auto-refreshes (pins 0,0,0,1), and a final mode set.
- R5: The extended mode set uses pins 0,0,0,0 and `ba`=01. Its address is EMR_VAL with bit 0 (the DLL-disable bit) forced to 0.
- R6: Both mode sets use pins 0,0,0,0 and `ba`=00. The first carries MR_VAL with bit 8 (DLL reset) forced to 1, and the final one carries MR_VAL with bit 8 forced to 0.
- R7: The spacing in cycles from one command to the next is as follows: precharge to the next command, TRP_CYC; extended mode set to mode set, TMRD_CYC; DLL-reset mode set to the second precharge, the larger of LOCK_CYC and TMRD_CYC; each refresh to the next command, TRFC_CYC.
- R8: Each command lasts exactly one cycle, and all other cycles carry NOP.
- R9: `init_done` rises exactly TMRD_CYC cycles after the final mode set. From then on it stays high, with `cke` high and NOP on the pins, until reset.
- R10: A synchronous reset taken at any point returns the block to the R1 state. A new full sequence starts once `pwr_good` is seen high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_good | input | 1 | Supplies are stable |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| addr | output | 13 | Address bus |
| init_done | output | 1 | Initialization complete |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of the long DLL-lock wait, after several commands have already gone out. The bench runs a full sequence and then restarts it with `pwr_good` held high. It counts cycles until it is inside the lock gap and then pulses reset there. It confirms that the block falls back to the powered-down state, that it stays there while `pwr_good` is low, and that it later completes a fresh sequence. The command train itself is checked against a table of expected pins, bank, address and gap for each step, using small wait counts and three refreshes.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  localparam int ADDR_W    = 13;
  localparam int BIT_DLLOFF = 0;
  localparam int BIT_DLLRST = 8;
  localparam int BIT_ALLBK  = 10;

  typedef enum logic [3:0] {
    ST_PWR, ST_STABLE, ST_CKE, ST_PRE1, ST_EMRS, ST_MRS_RST,
    ST_PRE2, ST_REF, ST_MRS_FIN, ST_GAP, ST_DONE
  } st_e;

  typedef enum logic [2:0] {C_NOP, C_PRE_ALL, C_REF, C_MRS, C_EMRS} cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] pins_of(cmd_e c);
    case (c)
      C_PRE_ALL:      return 4'b0010;
      C_REF:          return 4'b0001;
      C_MRS, C_EMRS:  return 4'b0000;
      default:        return 4'b0111;
    endcase
  endfunction

  function automatic logic [1:0] bank_of(cmd_e c);
    return (c == C_EMRS) ? 2'b01 : 2'b00;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [ADDR_W-1:0] emr_word(logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    r = v;
    r[BIT_DLLOFF] = 1'b0;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] mr_word(logic [ADDR_W-1:0] v, logic dll_rst);
    logic [ADDR_W-1:0] r;
    r = v;
    r[BIT_DLLRST] = dll_rst;
    return r;
  endfunction
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
  end
  assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
(
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              is_pre
);
  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = pins_of(cmd);
    ba     = bank_of(cmd);
    addr   = addr_in;
    is_pre = (cmd == C_PRE_ALL);
    if (cmd == C_PRE_ALL) addr[BIT_ALLBK] = 1'b1;
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int              STABLE_CYC  = 25000,
  parameter int              CKE_NOP_CYC = 4,
  parameter int              TRP_CYC     = 3,
  parameter int              TMRD_CYC    = 2,
  parameter int              LOCK_CYC    = 200,
  parameter int              TRFC_CYC    = 9,
  parameter int              NUM_REF     = 2,
  parameter logic [12:0]     EMR_VAL     = 13'h0000,
  parameter logic [12:0]     MR_VAL      = 13'h0032
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pwr_good,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [12:0] addr,
  output logic        init_done
);
  localparam int STABLE_G = max2(STABLE_CYC, 1);
  localparam int CKE_G    = max2(CKE_NOP_CYC, 1);
  localparam int TRP_G    = max2(TRP_CYC, 2);
  localparam int TMRD_G   = max2(TMRD_CYC, 2);
  localparam int TRFC_G   = max2(TRFC_CYC, 2);
  localparam int LOCK_G   = max2(max2(LOCK_CYC, TMRD_G), 2);
  localparam int REF_N    = max2(NUM_REF, 2);
  localparam int MAX_CNT  = max2(max2(STABLE_G, LOCK_G),
                                 max2(max2(TRP_G, TMRD_G), max2(TRFC_G, CKE_G)));
  localparam int CNT_W    = $clog2(MAX_CNT + 1);
  localparam int REF_W    = $clog2(REF_N + 1);

  st_e               st, st_nxt, after_gap, after_gap_nxt;
  logic [REF_W-1:0]  ref_cnt;
  logic              ref_inc;
  logic              t_load, t_dec, t_last;
  logic [CNT_W-1:0]  t_val, t_cnt;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr_c;
  logic              cke_c, done_c;

  // named events for the checker
  logic              in_gap, cmd_fire, pre_fire;
  logic [31:0]       gap_cnt;

  always_comb begin
    st_nxt        = st;
    after_gap_nxt = after_gap;
    t_load        = 1'b0;
    t_val         = '0;
    t_dec         = 1'b0;
    ref_inc       = 1'b0;
    cmd           = C_NOP;
    addr_c        = '0;
    cke_c         = 1'b1;
    done_c        = 1'b0;
    case (st)
      ST_PWR: begin
        cke_c = 1'b0;
        if (pwr_good) begin
          st_nxt = ST_STABLE; t_load = 1'b1; t_val = CNT_W'(STABLE_G);
        end
      end
      ST_STABLE: begin
        cke_c = 1'b0; t_dec = 1'b1;
        if (t_last) begin
          st_nxt = ST_CKE; t_load = 1'b1; t_val = CNT_W'(CKE_G);
        end
      end
      ST_CKE: begin
        t_dec = 1'b1;
        if (t_last) st_nxt = ST_PRE1;
      end
      ST_PRE1: begin
        cmd = C_PRE_ALL; st_nxt = ST_GAP; after_gap_nxt = ST_EMRS;
        t_load = 1'b1; t_val = CNT_W'(TRP_G - 1);
      end
      ST_EMRS: begin
        cmd = C_EMRS; addr_c = emr_word(EMR_VAL);
        st_nxt = ST_GAP; after_gap_nxt = ST_MRS_RST;
        t_load = 1'b1; t_val = CNT_W'(TMRD_G - 1);
      end
      ST_MRS_RST: begin
        cmd = C_MRS; addr_c = mr_word(MR_VAL, 1'b1);
        st_nxt = ST_GAP; after_gap_nxt = ST_PRE2;
        t_load = 1'b1; t_val = CNT_W'(LOCK_G - 1);
      end
      ST_PRE2: begin
        cmd = C_PRE_ALL; st_nxt = ST_GAP; after_gap_nxt = ST_REF;
        t_load = 1'b1; t_val = CNT_W'(TRP_G - 1);
      end
      ST_REF: begin
        cmd = C_REF; ref_inc = 1'b1; st_nxt = ST_GAP;
        after_gap_nxt = (ref_cnt == REF_W'(REF_N - 1)) ? ST_MRS_FIN : ST_REF;
        t_load = 1'b1; t_val = CNT_W'(TRFC_G - 1);
      end
      ST_MRS_FIN: begin
        cmd = C_MRS; addr_c = mr_word(MR_VAL, 1'b0);
        st_nxt = ST_GAP; after_gap_nxt = ST_DONE;
        t_load = 1'b1; t_val = CNT_W'(TMRD_G - 1);
      end
      ST_GAP: begin
        t_dec = 1'b1;
        if (t_last) st_nxt = after_gap;
      end
      ST_DONE: done_c = 1'b1;
      default: st_nxt = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWR;
      after_gap <= ST_PWR;
      ref_cnt   <= '0;
    end else begin
      st        <= st_nxt;
      after_gap <= after_gap_nxt;
      if (ref_inc) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .dec(t_dec), .cnt(t_cnt), .last(t_last)
  );

  ddr_init_cmd_enc u_enc (
    .cmd(cmd), .addr_in(addr_c), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .is_pre(pre_fire)
  );

  assign cke       = cke_c;
  assign init_done = done_c;
  assign in_gap    = (st == ST_GAP);
  assign cmd_fire  = (cmd != C_NOP);
  assign gap_cnt   = 32'(t_cnt);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [12:0] addr,
  input logic        init_done,
  input logic        in_gap,
  input logic        cmd_fire,
  input logic        pre_fire,
  input logic [31:0] gap_cnt
);
  AST_NO_CMD_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111)); // R2
  AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke); // R3
  AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (rst)
    pre_fire |-> (addr[10] && !cs_n && !ras_n && cas_n && !we_n)); // R3
  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> !cmd_fire); // R8
  AST_GAP_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    in_gap |-> (gap_cnt != 32'd0)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && !cmd_fire)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (!cke && !init_done)); // R10
endmodule

bind ddr_init_seq ddr_init_seq_chk u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .addr(addr), .init_done(init_done),
  .in_gap(in_gap), .cmd_fire(cmd_fire), .pre_fire(pre_fire), .gap_cnt(gap_cnt)
);

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
  localparam int          ST   = 20;
  localparam int          CN   = 3;
  localparam int          TRP  = 3;
  localparam int          TMRD = 2;
  localparam int          LOCK = 200;
  localparam int          TRFC = 7;
  localparam int          NREF = 3;
  localparam logic [12:0] EMR  = 13'h0043;
  localparam logic [12:0] MR   = 13'h0162;

  localparam logic [12:0] EMR_EXP = EMR & 13'h1FFE;
  localparam logic [12:0] MR_RST  = MR | 13'h0100;
  localparam logic [12:0] MR_FIN  = MR & 13'h1EFF;
  localparam logic [3:0]  P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;

  // {pins[34:31], ba[30:29], addr[28:16], gap from previous event[15:0]}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {P_PRE, 2'b00, 13'h0400, 16'(CN)},
    {P_MRS, 2'b01, EMR_EXP,  16'(TRP)},
    {P_MRS, 2'b00, MR_RST,   16'(TMRD)},
    {P_PRE, 2'b00, 13'h0400, 16'(LOCK)},
    {P_REF, 2'b00, 13'h0000, 16'(TRP)},
    {P_REF, 2'b00, 13'h0000, 16'(TRFC)},
    {P_REF, 2'b00, 13'h0000, 16'(TRFC)},
    {P_MRS, 2'b00, MR_FIN,   16'(TRFC)}
  };
  localparam string VTAG [NV] = '{"R3 R4", "R5 R7", "R6 R7", "R4 R7",
                                  "R4 R7", "R4 R7", "R4 R7", "R6 R7"};

  logic clk = 1'b0, rst = 1'b1, pwr_good = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [12:0] addr;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_init_seq #(.STABLE_CYC(ST), .CKE_NOP_CYC(CN), .TRP_CYC(TRP), .TMRD_CYC(TMRD),
    .LOCK_CYC(LOCK), .TRFC_CYC(TRFC), .NUM_REF(NREF), .EMR_VAL(EMR), .MR_VAL(MR))
  u_ddr_init_seq (.clk(clk), .rst(rst), .pwr_good(pwr_good), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_cmd();
    return {cs_n, ras_n, cas_n, we_n} != 4'b0111;
  endfunction

  task automatic wait_cmd(output int at);
    int n = 0;
    do begin @(negedge clk); n++; end while (!is_cmd() && n < 600);
    at = cyc;
  endtask

  initial begin
    int c0, at, n, bad;
    repeat (3) @(negedge clk);
    chk(!cke && !init_done, "R1", {cke, init_done}, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    rst = 1'b0;
    bad = 0;
    repeat (30) begin @(negedge clk); if (cke || init_done || is_cmd()) bad++; end
    chk(bad == 0, "R1", bad, 0);

    pwr_good = 1'b1;
    n = 0; bad = 0;
    do begin @(negedge clk); n++; if (!cke && is_cmd()) bad++; end while (!cke && n < 1000);
    chk(n == ST + 1, "R2", n, ST + 1);
    chk(bad == 0, "R2", bad, 0);
    c0 = cyc;

    // table walk: command train, pins, bank, address and spacing
    for (int i = 0; i < NV; i++) begin
      wait_cmd(at);
      chk({cs_n, ras_n, cas_n, we_n} == VEC[i][34:31], VTAG[i], {cs_n, ras_n, cas_n, we_n}, VEC[i][34:31]);
      chk(ba == VEC[i][30:29], VTAG[i], ba, VEC[i][30:29]);
      chk(addr == VEC[i][28:16], VTAG[i], addr, VEC[i][28:16]);
      chk(at - c0 == int'(VEC[i][15:0]), VTAG[i], at - c0, VEC[i][15:0]);
      chk(cke, "R3", cke, 1);
      @(negedge clk);
      chk(!is_cmd(), "R8", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      c0 = at;
    end

    n = 0;
    while (!init_done && n < 100) begin @(negedge clk); n++; end
    chk(cyc - c0 == TMRD, "R9", cyc - c0, TMRD);
    bad = 0;
    repeat (25) begin @(negedge clk); if (!init_done || !cke || is_cmd()) bad++; end
    chk(bad == 0, "R9", bad, 0);

    // reset inside the DLL lock gap, with power still good
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    repeat (ST + CN + TRP + TMRD + 60) @(negedge clk);
    chk(cke && !init_done, "R10", {cke, init_done}, 2'b10);
    rst = 1'b1; pwr_good = 1'b0;
    @(negedge clk);
    chk(!cke && !init_done, "R10", {cke, init_done}, 0);
    rst = 1'b0;
    bad = 0;
    repeat (40) begin @(negedge clk); if (cke || init_done || is_cmd()) bad++; end
    chk(bad == 0, "R10", bad, 0);
    pwr_good = 1'b1;
    n = 0;
    while (!init_done && n < 2000) begin @(negedge clk); n++; end
    chk(init_done, "R10", init_done, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog expired actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule